// File: doc/BRIEF.md
# Variable-Node Message Processor

This block is the variable-node update engine of a configurable quasi-cyclic LDPC decoder. Each use takes the channel LLR of one code bit together with the check-to-variable messages arriving on that bit's edges. It returns three things: one variable-to-check message per connected edge, the a-posteriori total for the bit, and the hard decision the decoder uses to stop iterating. The message on an edge is the intrinsic value plus every incoming message except the one that arrived on that edge.

The number of message ports is fixed by the largest column weight the decoder must handle. A degree input says how many of those ports carry real edges for the current column. Ports at or above the degree are treated as zero on the way in and are driven to zero on the way out, so one instance serves columns of every weight. An init input loads the intrinsic LLR onto every active edge, which is how the first iteration of a frame is started. Results are registered and appear one cycle after the input cycle, with a valid flag beside them.

Top module: `vnode_update`

## Requirements
- R1: Under normal operation, `app_out` equals `llr_in` plus the sum of the messages on the active ports, computed exactly in two's complement with APP_W bits and with no saturation.
- R2: For each active port k (k below the effective degree), the field `v2c_out[k*MSG_W +: MSG_W]` equals the saturated value of (`app_out` minus that port's input). Port k occupies bits `[k*MSG_W +: MSG_W]` of both `c2v_in` and `v2c_out`, in two's complement.
- R3: Saturation clips to the range [-(2^(MSG_W-1)-1), 2^(MSG_W-1)-1] when SAT_MODE is symmetric (the default), and to [-2^(MSG_W-1), 2^(MSG_W-1)-1] when SAT_MODE is plain two's complement. In symmetric mode the most negative code never appears on an output.
- R4: `hard_bit` is 0 when `app_out` is strictly positive and 1 when it is zero or negative.
- R5: Input ports at or above the effective degree have no effect on any result, and their output fields are 0. A degree of 0 gives `app_out` equal to `llr_in` and all output fields 0.
- R6: A degree value above MAX_DEG behaves exactly like MAX_DEG.
- R7: With `init` high, every active output field equals the saturated `llr_in`, `app_out` equals `llr_in`, and `hard_bit` follows R4 on that value. The message inputs are ignored.
- R8: Results and `out_valid` appear one cycle after a cycle with `in_valid` high, and `out_valid` is low one cycle after a cycle with `in_valid` low.
- R9: In a cycle without `in_valid`, `v2c_out`, `app_out` and `hard_bit` keep their previous values.
- R10: After reset, `out_valid`, `v2c_out`, `app_out` and `hard_bit` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Inputs of this cycle are to be processed |
| init | input | 1 | Start of frame: load the intrinsic LLR onto every active edge |
| degree | input | DEG_W | Number of active edges of the column |
| llr_in | input | LLR_W | Intrinsic channel LLR, two's complement |
| c2v_in | input | MAX_DEG*MSG_W | Check-to-variable messages, port k at bits [k*MSG_W +: MSG_W] |
| out_valid | output | 1 | Registered results are new this cycle |
| v2c_out | output | MAX_DEG*MSG_W | Variable-to-check messages, same field layout as c2v_in |
| app_out | output | APP_W | A-posteriori total with guard bits |
| hard_bit | output | 1 | Hard decision, 0 for a positive total |

## Verification
All results of an input cycle are captured by the next rising edge, so the messages, the total, the hard decision and the valid flag are all due one edge after the inputs are presented. Every expected item is queued together with the cycle number at which it must appear. The monitor samples at the falling edge between rising edges, and it flags any item that arrives in a different cycle, any valid flag that has no queued item, and any item still queued at the end. In cycles without a result, the monitor compares the outputs with the last result to confirm that they hold.

// File: rtl/vnu_pkg.sv
package vnu_pkg;

   typedef enum logic {
      SAT_TWOS = 1'b0,
      SAT_SYM  = 1'b1
   } sat_mode_e;

   function automatic int acc_width(int msg_w, int llr_w, int max_deg);
      int wide;
      wide = (msg_w > llr_w) ? msg_w : llr_w;
      return wide + $clog2(max_deg + 1);
   endfunction

endpackage

// File: rtl/vnu_port_mask.sv
module vnu_port_mask #(
   parameter int MSG_W   = 6,
   parameter int MAX_DEG = 6,
   parameter int DEG_W   = 3,
   parameter int ACC_W   = 9
) (
   input  logic [DEG_W-1:0]               degree,
   input  logic [MAX_DEG*MSG_W-1:0]       c2v_flat,
   output logic [MAX_DEG-1:0]             edge_on,
   output logic [MAX_DEG-1:0][ACC_W-1:0]  msg_ext
);
   localparam int EXT_W = ACC_W - MSG_W;

   logic [DEG_W-1:0] deg_eff;

   always_comb begin
      if (int'(degree) > MAX_DEG) deg_eff = DEG_W'(MAX_DEG);
      else                        deg_eff = degree;
   end

   for (genvar k = 0; k < MAX_DEG; k++) begin : g_port
      logic [MSG_W-1:0] raw;
      assign raw        = c2v_flat[k*MSG_W +: MSG_W];
      assign edge_on[k] = (int'(deg_eff) > k);
      assign msg_ext[k] = edge_on[k] ? {{EXT_W{raw[MSG_W-1]}}, raw} : '0;
   end

endmodule

// File: rtl/vnu_sum.sv
module vnu_sum #(
   parameter int MAX_DEG = 6,
   parameter int ACC_W   = 9
) (
   input  logic [ACC_W-1:0]               llr_ext,
   input  logic [MAX_DEG-1:0][ACC_W-1:0]  msg_ext,
   output logic [ACC_W-1:0]               total
);
   logic [ACC_W-1:0] part [MAX_DEG+1];

   assign part[0] = llr_ext;

   for (genvar k = 0; k < MAX_DEG; k++) begin : g_acc
      assign part[k+1] = part[k] + msg_ext[k];
   end

   assign total = part[MAX_DEG];

endmodule

// File: rtl/vnu_edge_out.sv
module vnu_edge_out #(
   parameter int                  MSG_W    = 6,
   parameter int                  MAX_DEG  = 6,
   parameter int                  ACC_W    = 9,
   parameter vnu_pkg::sat_mode_e  SAT_MODE = vnu_pkg::SAT_SYM
) (
   input  logic                           init,
   input  logic [MAX_DEG-1:0]             edge_on,
   input  logic [ACC_W-1:0]               llr_ext,
   input  logic [ACC_W-1:0]               total,
   input  logic [MAX_DEG-1:0][ACC_W-1:0]  msg_ext,
   output logic [MAX_DEG*MSG_W-1:0]       v2c_next
);
   localparam logic signed [ACC_W-1:0] SAT_HI = ACC_W'((2 ** (MSG_W - 1)) - 1);
   localparam logic signed [ACC_W-1:0] SAT_LO = -SAT_HI;
   localparam int TOP_W = ACC_W - MSG_W + 1;

   for (genvar k = 0; k < MAX_DEG; k++) begin : g_edge
      logic signed [ACC_W-1:0] src;
      logic [MSG_W-1:0]        clip;

      assign src = init ? $signed(llr_ext) : $signed(total - msg_ext[k]);

      if (SAT_MODE == vnu_pkg::SAT_SYM) begin : g_sym
         always_comb begin
            if (src > SAT_HI)      clip = SAT_HI[MSG_W-1:0];
            else if (src < SAT_LO) clip = SAT_LO[MSG_W-1:0];
            else                   clip = src[MSG_W-1:0];
         end
      end else begin : g_twos
         logic [TOP_W-1:0] top_bits;
         logic             ovf;
         assign top_bits = src[ACC_W-1:MSG_W-1];
         assign ovf      = (|top_bits) && !(&top_bits);
         always_comb begin
            if (!ovf)             clip = src[MSG_W-1:0];
            else if (src[ACC_W-1]) clip = {1'b1, {(MSG_W-1){1'b0}}};
            else                   clip = {1'b0, {(MSG_W-1){1'b1}}};
         end
      end

      assign v2c_next[k*MSG_W +: MSG_W] = edge_on[k] ? clip : '0;
   end

endmodule

// File: rtl/vnode_update.sv
module vnode_update #(
   parameter int                  MSG_W    = 6,
   parameter int                  LLR_W    = 6,
   parameter int                  MAX_DEG  = 6,
   parameter vnu_pkg::sat_mode_e  SAT_MODE = vnu_pkg::SAT_SYM,
   localparam int                 DEG_W    = $clog2(MAX_DEG + 1),
   localparam int                 APP_W    = vnu_pkg::acc_width(MSG_W, LLR_W, MAX_DEG)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       in_valid,
   input  logic                       init,
   input  logic [DEG_W-1:0]           degree,
   input  logic [LLR_W-1:0]           llr_in,
   input  logic [MAX_DEG*MSG_W-1:0]   c2v_in,
   output logic                       out_valid,
   output logic [MAX_DEG*MSG_W-1:0]   v2c_out,
   output logic [APP_W-1:0]           app_out,
   output logic                       hard_bit
);
   if (MSG_W < 2) begin : g_bad_msg_w
      $error("vnode_update: MSG_W must be at least 2");
   end
   if (LLR_W < 2) begin : g_bad_llr_w
      $error("vnode_update: LLR_W must be at least 2");
   end
   if (MAX_DEG < 1) begin : g_bad_deg
      $error("vnode_update: MAX_DEG must be at least 1");
   end

   logic [APP_W-1:0]                 llr_ext;
   logic [MAX_DEG-1:0]               edge_on;
   logic [MAX_DEG-1:0][APP_W-1:0]    msg_ext;
   logic [APP_W-1:0]                 total;
   logic [APP_W-1:0]                 app_next;
   logic                             hard_next;
   logic [MAX_DEG*MSG_W-1:0]         v2c_next;

   assign llr_ext = {{(APP_W-LLR_W){llr_in[LLR_W-1]}}, llr_in};

   vnu_port_mask #(
      .MSG_W   (MSG_W),
      .MAX_DEG (MAX_DEG),
      .DEG_W   (DEG_W),
      .ACC_W   (APP_W)
   ) u_mask (
      .degree   (degree),
      .c2v_flat (c2v_in),
      .edge_on  (edge_on),
      .msg_ext  (msg_ext)
   );

   vnu_sum #(
      .MAX_DEG (MAX_DEG),
      .ACC_W   (APP_W)
   ) u_sum (
      .llr_ext (llr_ext),
      .msg_ext (msg_ext),
      .total   (total)
   );

   vnu_edge_out #(
      .MSG_W    (MSG_W),
      .MAX_DEG  (MAX_DEG),
      .ACC_W    (APP_W),
      .SAT_MODE (SAT_MODE)
   ) u_edge (
      .init     (init),
      .edge_on  (edge_on),
      .llr_ext  (llr_ext),
      .total    (total),
      .msg_ext  (msg_ext),
      .v2c_next (v2c_next)
   );

   assign app_next  = init ? llr_ext : total;
   assign hard_next = ($signed(app_next) <= 0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         v2c_out   <= '0;
         app_out   <= '0;
         hard_bit  <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            v2c_out  <= v2c_next;
            app_out  <= app_next;
            hard_bit <= hard_next;
         end
      end
   end

endmodule

// File: rtl/vnu_update_chk.sv
module vnu_update_chk #(
   parameter int                  MSG_W    = 6,
   parameter int                  LLR_W    = 6,
   parameter int                  MAX_DEG  = 6,
   parameter vnu_pkg::sat_mode_e  SAT_MODE = vnu_pkg::SAT_SYM,
   localparam int                 DEG_W    = $clog2(MAX_DEG + 1),
   localparam int                 APP_W    = vnu_pkg::acc_width(MSG_W, LLR_W, MAX_DEG)
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       in_valid,
   input logic                       init,
   input logic [DEG_W-1:0]           degree,
   input logic [LLR_W-1:0]           llr_in,
   input logic [MAX_DEG*MSG_W-1:0]   c2v_in,
   input logic                       out_valid,
   input logic [MAX_DEG*MSG_W-1:0]   v2c_out,
   input logic [APP_W-1:0]           app_out,
   input logic                       hard_bit
);
   logic [APP_W-1:0] llr_sx;
   logic [DEG_W-1:0] deg_c;

   assign llr_sx = {{(APP_W-LLR_W){llr_in[LLR_W-1]}}, llr_in};
   assign deg_c  = (int'(degree) > MAX_DEG) ? DEG_W'(MAX_DEG) : degree;

   assert_valid_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   assert_valid_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(v2c_out) && $stable(app_out) && $stable(hard_bit)));

   assert_hard_sign_R4: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (hard_bit == ($signed(app_out) <= 0)));

   assert_init_total_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && init) |=> (app_out == $past(llr_sx)));

   for (genvar k = 0; k < MAX_DEG; k++) begin : g_port_chk
      assert_unused_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && (int'(deg_c) <= k)) |=> (v2c_out[k*MSG_W +: MSG_W] == '0));

      if (SAT_MODE == vnu_pkg::SAT_SYM) begin : g_sym_chk
         assert_sym_clip_R3: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (v2c_out[k*MSG_W +: MSG_W] != {1'b1, {(MSG_W-1){1'b0}}}));
      end
   end

endmodule

bind vnode_update vnu_update_chk #(
   .MSG_W    (MSG_W),
   .LLR_W    (LLR_W),
   .MAX_DEG  (MAX_DEG),
   .SAT_MODE (SAT_MODE)
) u_vnu_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .init      (init),
   .degree    (degree),
   .llr_in    (llr_in),
   .c2v_in    (c2v_in),
   .out_valid (out_valid),
   .v2c_out   (v2c_out),
   .app_out   (app_out),
   .hard_bit  (hard_bit)
);

// File: tb/vnode_update_bench.sv
`timescale 1ns/1ps
module vnode_update_bench;
   localparam int MSG_W   = 6;
   localparam int LLR_W   = 6;
   localparam int MAX_DEG = 6;
   localparam int DEG_W   = 3;
   localparam int APP_W   = 9;
   localparam int SAT_HI  = 31;
   localparam int SAT_LO  = -31;

   logic                     clk;
   logic                     rst_n;
   logic                     in_valid;
   logic                     init;
   logic [DEG_W-1:0]         degree;
   logic [LLR_W-1:0]         llr_in;
   logic [MAX_DEG*MSG_W-1:0] c2v_in;
   logic                     out_valid;
   logic [MAX_DEG*MSG_W-1:0] v2c_out;
   logic [APP_W-1:0]         app_out;
   logic                     hard_bit;

   vnode_update u_vnode_update (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .init      (init),
      .degree    (degree),
      .llr_in    (llr_in),
      .c2v_in    (c2v_in),
      .out_valid (out_valid),
      .v2c_out   (v2c_out),
      .app_out   (app_out),
      .hard_bit  (hard_bit)
   );

   typedef struct {
      logic [MAX_DEG*MSG_W-1:0] v2c;
      int                       app;
      bit                       hard;
      int                       due;
      string                    req;
   } exp_t;

   exp_t sb[$];
   exp_t cur;
   int   cmsg [MAX_DEG];
   int   cyc = 0;
   int   n_total = 0;
   int   n_bad = 0;
   bit   done = 0;
   bit   have_last = 0;
   logic [MAX_DEG*MSG_W-1:0] last_v2c;
   logic [APP_W-1:0]         last_app;
   logic                     last_hard;

   initial clk = 1'b0;
   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(bit ok, string req, string what, string act, string exp);
      n_total++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%s expected=%s", req, what, act, exp);
      end
   endtask

   function automatic int sat(int x);
      if (x > SAT_HI) return SAT_HI;
      if (x < SAT_LO) return SAT_LO;
      return x;
   endfunction

   task automatic set6(int a, int b, int c, int d, int e, int f);
      cmsg[0] = a; cmsg[1] = b; cmsg[2] = c;
      cmsg[3] = d; cmsg[4] = e; cmsg[5] = f;
   endtask

   task automatic send(int deg, bit ini, int llr, string req);
      exp_t it;
      int   de;
      int   app;
      @(negedge clk);
      de  = (deg > MAX_DEG) ? MAX_DEG : deg;
      app = llr;
      if (!ini) for (int k = 0; k < de; k++) app += cmsg[k];
      it.v2c = '0;
      for (int k = 0; k < de; k++)
         it.v2c[k*MSG_W +: MSG_W] = MSG_W'(ini ? sat(llr) : sat(app - cmsg[k]));
      it.app  = app;
      it.hard = (app > 0) ? 1'b0 : 1'b1;
      it.due  = cyc + 1;
      it.req  = req;
      sb.push_back(it);
      in_valid = 1'b1;
      init     = ini;
      degree   = DEG_W'(deg);
      llr_in   = LLR_W'(llr);
      for (int k = 0; k < MAX_DEG; k++) c2v_in[k*MSG_W +: MSG_W] = MSG_W'(cmsg[k]);
   endtask

   task automatic idle(int n);
      repeat (n) begin
         @(negedge clk);
         in_valid = 1'b0;
         init     = 1'b0;
      end
   endtask

   // monitor: pops the scoreboard whenever a result is flagged
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (out_valid) begin
            if (sb.size() == 0) begin
               check(1'b0, "R8", "out_valid without pending item", "1", "0");
            end else begin
               cur = sb.pop_front();
               check(cyc == cur.due, "R8", "result cycle",
                     $sformatf("%0d", cyc), $sformatf("%0d", cur.due));
               check(v2c_out == cur.v2c, cur.req, "v2c_out (R2)",
                     $sformatf("%h", v2c_out), $sformatf("%h", cur.v2c));
               check(int'($signed(app_out)) == cur.app, cur.req, "app_out (R1)",
                     $sformatf("%0d", $signed(app_out)), $sformatf("%0d", cur.app));
               check(hard_bit == cur.hard, cur.req, "hard_bit (R4)",
                     $sformatf("%0d", hard_bit), $sformatf("%0d", cur.hard));
               last_v2c  = v2c_out;
               last_app  = app_out;
               last_hard = hard_bit;
               have_last = 1'b1;
            end
         end else if (have_last) begin
            check((v2c_out == last_v2c) && (app_out == last_app) && (hard_bit == last_hard),
                  "R9", "outputs held",
                  $sformatf("%h/%h/%0d", v2c_out, app_out, hard_bit),
                  $sformatf("%h/%h/%0d", last_v2c, last_app, last_hard));
         end
      end
   end

   initial begin
      #500000;
      if (!done) begin
         done = 1'b1;
         n_total++;
         n_bad++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("test done: total=%0d bad=%0d", n_total, n_bad);
         $finish;
      end
   end

   initial begin
      rst_n    = 1'b0;
      in_valid = 1'b0;
      init     = 1'b0;
      degree   = '0;
      llr_in   = '0;
      c2v_in   = '0;
      repeat (3) @(negedge clk);
      // R10: reset state
      check((out_valid == 1'b0) && (v2c_out == '0) && (app_out == '0) && (hard_bit == 1'b0),
            "R10", "reset outputs",
            $sformatf("%0d/%h/%h/%0d", out_valid, v2c_out, app_out, hard_bit), "0/0/0/0");
      @(negedge clk);
      rst_n = 1'b1;
      idle(2);

      // R3: positive and negative clipping at full degree
      set6(31, 31, 31, 31, 31, 31);
      send(6, 1'b0, 31, "R3");
      set6(-32, -32, -32, -32, -32, -32);
      send(6, 1'b0, -32, "R3");
      // R5: degree zero with garbage on every port
      set6(5, -7, 9, -20, 30, -1);
      send(0, 1'b0, 12, "R5");
      // R2 with R5: partial degree, garbage beyond it
      send(3, 1'b0, -4, "R2");
      // R6: out-of-range degree acts as full degree
      send(7, 1'b0, 3, "R6");
      // R7: init ignores messages, clips the intrinsic value
      send(4, 1'b1, -32, "R7");
      send(6, 1'b1, 17, "R7");
      // R4: zero total gives 1, one gives 0
      set6(3, -5, 28, 28, 28, 28);
      send(2, 1'b0, 2, "R4");
      send(2, 1'b0, 3, "R4");
      // R9: idle cycles hold the last result
      idle(3);
      set6(-1, 0, 0, 0, 0, 0);
      send(1, 1'b0, 1, "R4");
      idle(2);

      for (int n = 0; n < 300; n++) begin
         for (int k = 0; k < MAX_DEG; k++) cmsg[k] = int'($urandom_range(63)) - 32;
         send(int'($urandom_range(7)), ($urandom_range(7) == 0),
              int'($urandom_range(63)) - 32, "R2");
         if ($urandom_range(3) == 0) idle(int'($urandom_range(2)) + 1);
      end

      idle(4);
      check(sb.size() == 0, "R8", "scoreboard drained",
            $sformatf("%0d", sb.size()), "0");
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_total, n_bad);
      $finish;
   end

endmodule